// File: doc/BRIEF.md
# USB Host Controller Interrupt Register Block

This block is the interrupt unit of a USB host controller. Hardware event pulses set bits in a pending-status register, and software clears them by writing ones. A single mask register decides which pending events may raise the interrupt line. Software changes the mask through two write-one ports, one that sets bits and one that clears them. Both ports read back the same mask value.

Bit 31 of the mask is a global gate. The interrupt output is high only while that bit is set and at least one pending status bit has its own mask bit set. The register interface is a flat 32-bit port with a write strobe and a two-bit word address. Reads are combinational. Address 0 is the status register, address 1 the mask-set port, address 2 the mask-clear port, and address 3 is reserved.

Top module: `hc_irq_regs`

## Requirements
- R1: After reset, the status register, the mask and the interrupt output are all 0.
- R2: A 1 on bit n of `evt_i` in a cycle sets status bit n at the next clock edge, for the assigned bits n = 0..6 and 30. The bit then stays set until software clears it.
- R3: Writing address 0 clears every status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R4: If an event and a clearing write hit the same status bit in one cycle, the bit ends up set. Other bits named in the same write are still cleared.
- R5: Writing address 1 sets every writable mask bit whose data bit is 1. Mask bits whose data bit is 0 are unchanged.
- R6: Writing address 2 clears every mask bit whose data bit is 1. Mask bits whose data bit is 0 are unchanged.
- R7: Reads of address 1 and of address 2 both return the current mask.
- R8: Status bits 7..29 and 31 always read 0, whatever the events or writes. Only mask bits 0..6, 30 and 31 can be set; mask bits 7..29 always read 0.
- R9: `irq_o` is 1 exactly when mask bit 31 is 1 and, for some bit n in 0..6 or 30, both status bit n and mask bit n are 1.
- R10: While mask bit 31 is 0, `irq_o` is 0 whatever is pending and enabled.
- R11: Address 3 reads 0, and writes to it change neither status nor mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 2 | Word address: 0 status, 1 mask set, 2 mask clear, 3 reserved |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_i | input | 32 | Event pulses, bit n sets status bit n |
| irq_o | output | 1 | Interrupt request |

## Verification
A hardware event pulse and a software clear can both target the status register in the same cycle. This is provoked by raising an event bit in the very cycle that a status write carries a one in that bit and in another, pending bit. The check then reads back a status in which the event bit is still set and only the other bit has gone. The interrupt line is judged in the same pass. Its expected level is computed from the pending bits, the enables and the gate bit.

// File: rtl/hc_irq_pkg.sv
package hc_irq_pkg;
  localparam int REG_W      = 32;
  localparam int ADDR_W     = 2;
  localparam int GATE_BIT   = REG_W - 1;
  localparam logic [REG_W-1:0] STAT_USED_DEF = 32'h4000_007F;

  typedef enum logic [ADDR_W-1:0] {
    RA_STATUS = 2'd0,
    RA_ENSET  = 2'd1,
    RA_ENCLR  = 2'd2,
    RA_RSVD   = 2'd3
  } reg_addr_e;

  // next pending value: clears first, then new events override
  function automatic logic [REG_W-1:0] f_status_next(
      input logic [REG_W-1:0] cur, input logic [REG_W-1:0] set,
      input logic [REG_W-1:0] clr, input logic [REG_W-1:0] used);
    return ((cur & ~clr) | set) & used;
  endfunction

  function automatic logic [REG_W-1:0] f_mask_next(
      input logic [REG_W-1:0] cur, input logic [REG_W-1:0] set,
      input logic [REG_W-1:0] clr, input logic [REG_W-1:0] used);
    return ((cur | (set & used)) & ~clr);
  endfunction

  function automatic logic f_irq(input logic [REG_W-1:0] stat,
                                 input logic [REG_W-1:0] mask);
    logic [REG_W-2:0] hits;
    hits = stat[REG_W-2:0] & mask[REG_W-2:0];
    return mask[GATE_BIT] & (|hits);
  endfunction
endpackage

// File: rtl/hc_irq_status.sv
module hc_irq_status
  import hc_irq_pkg::*;
#(
  parameter logic [REG_W-1:0] USED = STAT_USED_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] set_i,
  input  logic [REG_W-1:0] clr_i,
  output logic [REG_W-1:0] stat_o
);
  logic [REG_W-1:0] stat_q;

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= f_status_next(stat_q, set_i, clr_i, USED);
  end

  assign stat_o = stat_q;

  // R3: a clear with no competing event empties the bit
  p_w1c_r3: assert property (@(posedge clk) disable iff (rst)
    (clr_i != '0) |=> ((stat_q & $past(clr_i & ~set_i)) == '0));

  // R4: an event is never lost, even against a clear
  p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
    ((set_i & USED) != '0) |=> ((stat_q & $past(set_i & USED)) == $past(set_i & USED)));

  // R8: unassigned bits stay zero
  p_unused_zero_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & ~USED) == '0));
endmodule

// File: rtl/hc_irq_mask.sv
module hc_irq_mask
  import hc_irq_pkg::*;
#(
  parameter logic [REG_W-1:0] USED = STAT_USED_DEF | (32'h1 << GATE_BIT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] set_i,
  input  logic [REG_W-1:0] clr_i,
  output logic [REG_W-1:0] mask_o
);
  logic [REG_W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= f_mask_next(mask_q, set_i, clr_i, USED);
  end

  assign mask_o = mask_q;

  // R5: set port raises the writable bits named
  p_mask_set_r5: assert property (@(posedge clk) disable iff (rst)
    ((set_i != '0) && (clr_i == '0)) |=>
      ((mask_q & $past(set_i & USED)) == $past(set_i & USED)));

  // R6: clear port drops the bits named
  p_mask_clr_r6: assert property (@(posedge clk) disable iff (rst)
    (clr_i != '0) |=> ((mask_q & $past(clr_i)) == '0));

  // R6: untouched bits hold
  p_mask_hold_r6: assert property (@(posedge clk) disable iff (rst)
    ((set_i == '0) && (clr_i == '0)) |=> $stable(mask_q));

  // R8: only writable bits can be set
  p_mask_used_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((mask_q & ~USED) == '0));
endmodule

// File: rtl/hc_irq_gate.sv
module hc_irq_gate
  import hc_irq_pkg::*;
(
  input  logic [REG_W-1:0] stat_i,
  input  logic [REG_W-1:0] mask_i,
  output logic             irq_o
);
  assign irq_o = f_irq(stat_i, mask_i);
endmodule

// File: rtl/hc_irq_regs.sv
module hc_irq_regs
  import hc_irq_pkg::*;
#(
  parameter logic [REG_W-1:0] STAT_USED = STAT_USED_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [REG_W-1:0]  evt_i,
  output logic              irq_o
);
  localparam logic [REG_W-1:0] MASK_USED = STAT_USED | (32'h1 << GATE_BIT);

  reg_addr_e        addr_e;
  logic [REG_W-1:0] stat_clr, mask_set, mask_clr;
  logic [REG_W-1:0] stat_w, mask_w;

  assign addr_e   = reg_addr_e'(bus_addr);
  assign stat_clr = (bus_wr && addr_e == RA_STATUS) ? bus_wdata : '0;
  assign mask_set = (bus_wr && addr_e == RA_ENSET)  ? bus_wdata : '0;
  assign mask_clr = (bus_wr && addr_e == RA_ENCLR)  ? bus_wdata : '0;

  hc_irq_status #(.USED(STAT_USED)) u_status (
    .clk(clk), .rst(rst), .set_i(evt_i), .clr_i(stat_clr), .stat_o(stat_w)
  );

  hc_irq_mask #(.USED(MASK_USED)) u_mask (
    .clk(clk), .rst(rst), .set_i(mask_set), .clr_i(mask_clr), .mask_o(mask_w)
  );

  hc_irq_gate u_gate (.stat_i(stat_w), .mask_i(mask_w), .irq_o(irq_o));

  always_comb begin
    unique case (addr_e)
      RA_STATUS:         bus_rdata = stat_w;
      RA_ENSET, RA_ENCLR: bus_rdata = mask_w;
      default:           bus_rdata = '0;
    endcase
  end

  // R10: gate bit low keeps the line quiet
  p_gate_r10: assert property (@(posedge clk) disable iff (rst)
    !mask_w[GATE_BIT] |-> !irq_o);

  // R9: a raised line always has a pending, enabled source
  p_source_r9: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ((stat_w & mask_w & STAT_USED) != '0));

  // R1: reset empties everything on the next cycle
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (stat_w == '0 && mask_w == '0 && !irq_o));
endmodule

// File: tb/hc_irq_regs_tb_top.sv
module hc_irq_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] evt_i = '0;
  logic        irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  bit          kind_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #10 clk = ~clk;

  hc_irq_regs dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i), .irq_o(irq_o)
  );

  // monitor: pops expected items and compares against the live outputs
  initial begin
    forever begin
      logic [31:0] act;
      wait (exp_q.size() > 0);
      act = kind_q[0] ? {31'd0, irq_o} : bus_rdata;
      n_cmp++;
      if (act !== exp_q[0]) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", tag_q[0], act, exp_q[0]);
      end
      void'(exp_q.pop_front());
      void'(kind_q.pop_front());
      void'(tag_q.pop_front());
    end
  end

  task automatic chk_rd(input logic [1:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_addr = a;
    #1;
    exp_q.push_back(e); kind_q.push_back(1'b0); tag_q.push_back(t);
    wait (exp_q.size() == 0);
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    #1;
    exp_q.push_back({31'd0, e}); kind_q.push_back(1'b1); tag_q.push_back(t);
    wait (exp_q.size() == 0);
  endtask

  task automatic cycle(input bit w, input logic [1:0] a, input logic [31:0] d,
                       input logic [31:0] ev);
    @(negedge clk);
    bus_wr = w; bus_addr = a; bus_wdata = d; evt_i = ev;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0; evt_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1
    chk_rd(2'd0, 32'h0, "R1 status after reset");
    chk_rd(2'd1, 32'h0, "R1 mask after reset");
    chk_irq(1'b0, "R1 irq after reset");
    // R2: events on bits 0, 6, 30
    cycle(1'b0, 2'd0, 32'h0, 32'h4000_0041);
    cycle(1'b0, 2'd0, 32'h0, 32'h0);
    chk_rd(2'd0, 32'h4000_0041, "R2 events latched and held");
    // R8: unassigned event bits
    cycle(1'b0, 2'd0, 32'h0, 32'hBFFF_FF80);
    chk_rd(2'd0, 32'h4000_0041, "R8 unassigned events ignored");
    // R3
    cycle(1'b1, 2'd0, 32'h0000_0001, 32'h0);
    chk_rd(2'd0, 32'h4000_0040, "R3 write-one clears bit 0");
    cycle(1'b1, 2'd0, 32'h0, 32'h0);
    chk_rd(2'd0, 32'h4000_0040, "R3 write-zero no effect");
    // R5 / R8 / R7
    cycle(1'b1, 2'd1, 32'hFFFF_FFFF, 32'h0);
    chk_rd(2'd1, 32'hC000_007F, "R5 R8 mask set, writable bits only");
    chk_rd(2'd2, 32'hC000_007F, "R7 clear port reads mask");
    chk_irq(1'b1, "R9 pending and enabled");
    // R10
    cycle(1'b1, 2'd2, 32'h8000_0000, 32'h0);
    chk_rd(2'd1, 32'h4000_007F, "R6 gate bit cleared");
    chk_irq(1'b0, "R10 gate low blocks irq");
    cycle(1'b1, 2'd1, 32'h8000_0000, 32'h0);
    chk_irq(1'b1, "R9 gate restored");
    cycle(1'b1, 2'd2, 32'h4000_0040, 32'h0);
    chk_rd(2'd2, 32'h8000_003F, "R6 clear named bits");
    chk_irq(1'b0, "R9 pending bits not enabled");
    cycle(1'b1, 2'd2, 32'h0, 32'h0);
    chk_rd(2'd1, 32'h8000_003F, "R6 write-zero no effect");
    cycle(1'b1, 2'd1, 32'h0, 32'h0);
    chk_rd(2'd1, 32'h8000_003F, "R5 write-zero no effect");
    // R4: event bit 2 with clear of bits 2 and 30 in one cycle
    cycle(1'b1, 2'd0, 32'h4000_0004, 32'h0000_0004);
    chk_rd(2'd0, 32'h0000_0044, "R4 set wins, other bit cleared");
    chk_irq(1'b1, "R9 bit 2 enabled");
    // R11
    cycle(1'b1, 2'd3, 32'hFFFF_FFFF, 32'h0);
    chk_rd(2'd3, 32'h0, "R11 reserved reads zero");
    chk_rd(2'd0, 32'h0000_0044, "R11 status untouched");
    chk_rd(2'd1, 32'h8000_003F, "R11 mask untouched");
    // R3 clear all
    cycle(1'b1, 2'd0, 32'hFFFF_FFFF, 32'h0);
    chk_rd(2'd0, 32'h0, "R3 clear all");
    chk_irq(1'b0, "R9 nothing pending");
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected completion", cyc);
    end
    #5;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule